// File: doc/BRIEF.md
# Serial Word Receiver with Idle-Gap End-of-Message Capture

This block sits behind a serial line decoder. Each bit of a serial data word arrives as a one-cycle strobe with its value, and the bits are shifted into a 32-bit assembly register with the first bit ending up most significant. A separate one-cycle tick marks each period of the serial receive clock. While no bits arrive, an idle-gap counter advances on those ticks. When it reaches a threshold set by software, the block pulses end of message, moves the assembled word into a holding buffer and sets a buffer-full flag.

Software programs the threshold and reads the word through a 16-bit register port. The threshold is write-only. The word is read as two halves, upper half first. Reading the upper half also captures the lower half into a shadow register. A word that completes between the two reads therefore cannot mix with the one being read. Software should choose a threshold shorter than the protocol's minimum gap between words, so that each word closes before the next one can start.

Top module: `msg_rx_capture`

## Requirements
- R1: Each bit strobe shifts the assembly register left by one and places the new bit in bit 0. The buffered word is the last 32 bits received, with the earliest of them in bit 31.
- R2: A write at address 2 with both byte enables set loads the gap threshold. A read at address 2 returns zero, so the threshold is write-only.
- R3: After the last bit of a word, the gap counter counts receive-clock ticks. A bit strobe restarts it at zero and wins over a tick in the same cycle. On the tick that brings it to the threshold, `eom` pulses high for exactly one cycle. The counter then holds until the next bit.
- R4: `eom` never fires without at least one bit received since the previous end of message. A threshold of zero, which is the reset value, disables end of message.
- R5: In the clock edge that raises `eom`, the holding buffer takes the assembled word and the assembly register clears to zero.
- R6: `buf_full` sets together with `eom` and clears after a read of address 1. If an end of message lands in the same cycle as that read, the flag stays set.
- R7: A read of address 0 returns bits 31:16 of the buffer and stores bits 15:0 in a shadow register. A read of address 1 returns the shadow. A word buffered between the two reads does not change the second result.
- R8: An access whose byte enables are not both set is ignored. Such a read returns zero and such a write leaves the threshold unchanged. Writes to addresses 0 and 1 have no effect.
- R9: `cpu_rdata` is registered and appears one cycle after the read. It holds its value while no read is made. Its reset value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | One pulse per serial receive-clock period |
| rx_bit_vld | input | 1 | Strobe: a received bit is present |
| rx_bit | input | 1 | Value of the received bit |
| eom | output | 1 | One-cycle end-of-message pulse |
| buf_full | output | 1 | Holding buffer has an unread word |
| cpu_sel | input | 1 | Register access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | 0 = upper half, 1 = lower half, 2 = gap threshold |
| cpu_be | input | 2 | Byte enables; both must be set |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |

## Verification
The bench aims at three races.

- **Tearing.** A new word completes between the upper-half and lower-half reads. A design without the shadow would return the new word's lower half.
- **End of message against a lower-half read.** Both happen in the same cycle. A design that lets the read win would drop the flag for a word nobody has read.
- **Bit against tick.** A bit and a tick arrive together. Counting the tick would close the word one period early.

It also covers the quiet cases: a zero threshold, partial-width writes and ticks on an idle line. A design that ignored any of these would raise `eom` or change the threshold where none was asked for. Random stretches of bursts, gaps and register traffic, with thresholds changed on the fly, are compared every cycle against a reference model.

// File: rtl/msg_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial word receiver: register map codes and
// the decoded CPU request. Assumes a 2-bit word address on the CPU port.
package msg_rx_pkg;

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned BE_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_GAP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic rd_zero;
        logic wr_gap;
    } cpu_req_t;

endpackage

// File: rtl/msg_rx_decode.sv
`timescale 1ns/1ps
// Decodes one CPU register access into single-purpose strobes.
// Assumes accesses last one cycle. Only full-width accesses (both byte
// enables set) are honoured. Any other read becomes a read-as-zero.
module msg_rx_decode
    import msg_rx_pkg::*;
(
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    output cpu_req_t          req
);

    logic     full_width;
    reg_sel_e sel_code;

    // Classify the access by width, direction and target register.
    always_comb begin
        full_width  = (cpu_be == {BE_W{1'b1}});
        sel_code    = reg_sel_e'(cpu_addr);
        req         = '0;
        req.rd_hi   = cpu_sel && !cpu_wr && full_width && (sel_code == SEL_HI);
        req.rd_lo   = cpu_sel && !cpu_wr && full_width && (sel_code == SEL_LO);
        req.wr_gap  = cpu_sel &&  cpu_wr && full_width && (sel_code == SEL_GAP);
        req.rd_zero = cpu_sel && !cpu_wr && !(req.rd_hi || req.rd_lo);
    end

endmodule

// File: rtl/msg_rx_gap_timer.sv
`timescale 1ns/1ps
// Idle-gap counter. While a word is open it counts receive-clock ticks
// with no bit. On the tick that reaches the threshold it closes the word.
// Assumes tick and bit strobes are synchronous single-cycle pulses.
// A threshold of zero disables closing.
module msg_rx_gap_timer #(
    parameter int unsigned GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bit_vld,
    input  logic [GAP_W-1:0] thr,
    output logic             eom_now,
    output logic             eom
);

    localparam int unsigned CNT_EXT = GAP_W + 1;

    logic [GAP_W-1:0]   cnt;
    logic               open_word;
    logic [CNT_EXT-1:0] cnt_inc;
    logic               reached;

    // Next count and threshold compare. A lowered threshold still closes.
    always_comb begin
        cnt_inc = {1'b0, cnt} + CNT_EXT'(1);
        reached = (cnt_inc >= {1'b0, thr});
        eom_now = open_word && tick && !bit_vld && (thr != '0) && reached;
    end

    // Counter, open-word state and the registered end-of-message pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            open_word <= 1'b0;
            eom       <= 1'b0;
        end else begin
            eom <= eom_now;
            if (bit_vld) begin
                cnt       <= '0;
                open_word <= 1'b1;
            end else if (eom_now) begin
                cnt       <= thr;
                open_word <= 1'b0;
            end else if (tick && open_word) begin
                cnt <= cnt_inc[GAP_W-1:0];
            end
        end
    end

endmodule

// File: rtl/msg_rx_shift.sv
`timescale 1ns/1ps
// Assembly shift register. Each bit strobe shifts left and inserts at
// bit 0, so the earliest bit ends up most significant. Cleared when the
// word is handed to the holding buffer. Assumes clr and bit_vld are never
// high together; the gap timer guarantees this.
module msg_rx_shift #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              clr,
    output logic [WORD_W-1:0] word
);

    // Shift in received bits and clear on hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (bit_vld) begin
            word <= {word[WORD_W-2:0], bit_in};
        end else if (clr) begin
            word <= '0;
        end
    end

endmodule

// File: rtl/msg_rx_hold.sv
`timescale 1ns/1ps
// Holding buffer, lower-half shadow, buffer-full flag and registered read
// data. Assumes the word is exactly two CPU halves wide. A read of the upper
// half snapshots the lower half, so a later load cannot tear the pair.
module msg_rx_hold
    import msg_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  cpu_req_t          req,
    output logic [DATA_W-1:0] rdata,
    output logic              full
);

    logic [WORD_W-1:0] held;
    logic [DATA_W-1:0] lo_shadow;
    logic [DATA_W-1:0] hi_half;
    logic [DATA_W-1:0] lo_half;

    // Split the held word into its two CPU halves.
    always_comb begin
        hi_half = held[WORD_W-1:DATA_W];
        lo_half = held[DATA_W-1:0];
    end

    // Take a completed word from the assembly register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load) begin
            held <= word_in;
        end
    end

    // Read data register and lower-half shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            lo_shadow <= '0;
        end else if (req.rd_hi) begin
            rdata     <= hi_half;
            lo_shadow <= lo_half;
        end else if (req.rd_lo) begin
            rdata <= lo_shadow;
        end else if (req.rd_zero) begin
            rdata <= '0;
        end
    end

    // Buffer-full flag: a new word wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
        end else if (req.rd_lo) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/msg_rx_capture.sv
`timescale 1ns/1ps
// Top of the serial word receiver. Shifts bits into an assembly register.
// Closes the word after a programmable idle gap of receive-clock ticks, then
// buffers it for reading as two halves. Assumes all inputs are synchronous
// to clk, with single-cycle strobes and accesses.
module msg_rx_capture
    import msg_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_tick,
    input  logic              rx_bit_vld,
    input  logic              rx_bit,
    output logic              eom,
    output logic              buf_full,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);

    localparam int unsigned WORD_W = 2 * DATA_W;

    cpu_req_t          req;
    logic [GAP_W-1:0]  gap_thr;
    logic              eom_now;
    logic [WORD_W-1:0] asm_word;

    msg_rx_decode u_dec (
        .cpu_sel  (cpu_sel),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_be   (cpu_be),
        .req      (req)
    );

    // Write-only gap threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_thr <= '0;
        end else if (req.wr_gap) begin
            gap_thr <= cpu_wdata[GAP_W-1:0];
        end
    end

    msg_rx_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (rx_tick),
        .bit_vld (rx_bit_vld),
        .thr     (gap_thr),
        .eom_now (eom_now),
        .eom     (eom)
    );

    msg_rx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (rx_bit_vld),
        .bit_in  (rx_bit),
        .clr     (eom_now),
        .word    (asm_word)
    );

    msg_rx_hold #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (eom_now),
        .word_in (asm_word),
        .req     (req),
        .rdata   (cpu_rdata),
        .full    (buf_full)
    );

endmodule

// File: rtl/msg_rx_chk.sv
`timescale 1ns/1ps
// Assertion checker for msg_rx_capture, attached with bind.
// Relates ports and internal strobes over time.
module msg_rx_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned GAP_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_bit_vld,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [1:0]        cpu_be,
    input logic              eom,
    input logic              buf_full,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              eom_now,
    input logic              rd_lo,
    input logic [GAP_W-1:0]  gap_thr
);

    // R3
    eom_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom |=> !eom);

    // R3
    bit_restarts_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_vld |=> !eom);

    // R4
    zero_thr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_thr == '0) |=> !eom);

    // R6
    full_with_eom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom |-> buf_full);

    // R6
    lo_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !eom_now) |=> !buf_full);

    // R8
    part_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && (cpu_be != 2'b11)) |=> (cpu_rdata == '0));

    // R8
    part_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && (cpu_be != 2'b11)) |=> $stable(gap_thr));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && !cpu_wr) |=> $stable(cpu_rdata));

endmodule

bind msg_rx_capture msg_rx_chk #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit_vld (rx_bit_vld),
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_be     (cpu_be),
    .eom        (eom),
    .buf_full   (buf_full),
    .cpu_rdata  (cpu_rdata),
    .eom_now    (eom_now),
    .rd_lo      (req.rd_lo),
    .gap_thr    (gap_thr)
);

// File: tb/msg_rx_capture_test.sv
`timescale 1ns/1ps
// Bench for msg_rx_capture: directed corner cases, then seeded random
// traffic. A cycle-level reference model is built from the requirements.
module msg_rx_capture_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_tick = 1'b0, rx_bit_vld = 1'b0, rx_bit = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0, cpu_be = 2'd0;
    logic [15:0] cpu_wdata = 16'd0;
    logic        eom, buf_full;
    logic [15:0] cpu_rdata;

    int total = 0;
    int bad   = 0;
    int wd_cnt = 0;
    bit finished = 0;

    // reference model state
    int          m_thr = 0, m_cnt = 0;
    bit          m_open = 0, m_full = 0, m_eom = 0;
    logic [31:0] m_asm = '0, m_buf = '0;
    logic [15:0] m_sh = '0, m_rd = '0;

    always #2 clk = ~clk;

    msg_rx_capture uut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_bit_vld(rx_bit_vld),
        .rx_bit(rx_bit), .eom(eom), .buf_full(buf_full), .cpu_sel(cpu_sel),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Does the reference model close the word this cycle?
    function automatic bit model_eom(input bit tk, input bit bv);
        return m_open && tk && !bv && (m_thr != 0) && (m_cnt + 1 >= m_thr);
    endfunction

    // One clock cycle: drive at negedge, advance the model, compare at the next negedge.
    task automatic step(input bit tk, input bit bv, input bit b,
                        input bit sel, input bit wr, input logic [1:0] ad,
                        input logic [1:0] be, input logic [15:0] wd, input string tag);
        bit en;
        rx_tick = tk; rx_bit_vld = bv; rx_bit = b;
        cpu_sel = sel; cpu_wr = wr; cpu_addr = ad; cpu_be = be; cpu_wdata = wd;
        en = model_eom(tk, bv);
        // CPU side uses the pre-edge buffer (R7, R8, R9)
        if (sel && !wr) begin
            if (be != 2'b11) m_rd = '0;
            else if (ad == 2'd0) begin m_rd = m_buf[31:16]; m_sh = m_buf[15:0]; end
            else if (ad == 2'd1) begin m_rd = m_sh; if (!en) m_full = 0; end
            else m_rd = '0;
        end
        // receive side (R1, R3, R5)
        if (bv) begin
            m_asm = {m_asm[30:0], b}; m_cnt = 0; m_open = 1;
        end else if (en) begin
            m_buf = m_asm; m_asm = '0; m_open = 0; m_cnt = m_thr; m_full = 1;
        end else if (tk && m_open) begin
            m_cnt++;
        end
        m_eom = en;
        if (sel && wr && be == 2'b11 && ad == 2'd2) m_thr = int'(wd);  // R2
        @(posedge clk);
        @(negedge clk);
        check(tag, "eom", {31'd0, eom}, {31'd0, m_eom});
        check(tag, "buf_full", {31'd0, buf_full}, {31'd0, m_full});
        check(tag, "cpu_rdata", {16'd0, cpu_rdata}, {16'd0, m_rd});
    endtask

    task automatic idle(input int n, input bit tk, input string tag);
        for (int i = 0; i < n; i++) step(tk, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic send(input logic [31:0] w, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) step(1, 1, w[i], 0, 0, 0, 0, 0, tag);
    endtask

    task automatic cpu(input bit wr, input logic [1:0] ad, input logic [1:0] be,
                       input logic [15:0] wd, input string tag);
        step(0, 0, 0, 1, wr, ad, be, wd, tag);
    endtask

    // watchdog
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R9, R6, R3)
        check("R9", "reset rdata", {16'd0, cpu_rdata}, 32'd0);
        check("R6", "reset full", {31'd0, buf_full}, 32'd0);
        check("R3", "reset eom", {31'd0, eom}, 32'd0);

        // zero threshold: no end of message (R4)
        send(32'h1234_5678, 32, "R4");
        idle(40, 1, "R4");
        // partial write leaves threshold at zero; gap reads as zero (R8, R2)
        cpu(1, 2'd2, 2'b01, 16'd3, "R8");
        cpu(1, 2'd2, 2'b10, 16'd3, "R8");
        idle(10, 1, "R8");
        cpu(0, 2'd2, 2'b11, 0, "R2");
        cpu(1, 2'd0, 2'b11, 16'hFFFF, "R8");
        // program threshold 4 and close a known word (R2, R3, R5, R1)
        cpu(1, 2'd2, 2'b11, 16'd4, "R2");
        idle(2, 1, "R4");
        send(32'hA5C3_1E7F, 32, "R1");
        idle(3, 1, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");   // no tick: counter waits
        idle(1, 1, "R3");                     // fourth tick closes
        idle(6, 1, "R4");
        cpu(0, 2'd0, 2'b11, 0, "R1");
        cpu(0, 2'd1, 2'b11, 0, "R1");
        // bit and tick together restart the gap (R3)
        send(32'h0000_00FF, 8, "R3");
        idle(3, 1, "R3");
        send(32'h1, 1, "R3");
        idle(5, 1, "R3");
        // tearing: upper read, new word lands, lower read still old (R7)
        cpu(0, 2'd0, 2'b11, 0, "R7");
        send(32'hDEAD_BEEF, 32, "R7");
        idle(5, 1, "R7");
        cpu(0, 2'd1, 2'b11, 0, "R7");
        cpu(0, 2'd1, 2'b01, 0, "R8");
        cpu(0, 2'd0, 2'b11, 0, "R7");
        cpu(0, 2'd1, 2'b11, 0, "R6");
        // end of message in the same cycle as a lower read (R6)
        cpu(1, 2'd2, 2'b11, 16'd2, "R2");
        send(32'h0F0F_3C3C, 32, "R6");
        idle(1, 1, "R6");
        step(1, 0, 0, 1, 0, 2'd1, 2'b11, 0, "R6");
        idle(2, 0, "R6");
        cpu(0, 2'd1, 2'b11, 0, "R6");

        // random traffic
        begin
            bit burst = 0;
            for (int c = 0; c < 6000; c++) begin
                bit tk, bv, sel, wr;
                logic [1:0] ad, be;
                logic [15:0] wd;
                if ($urandom % 40 == 0) burst = !burst;
                tk  = ($urandom % 2) == 1;
                bv  = burst && ($urandom % 4 != 0);
                sel = ($urandom % 4) == 0;
                wr  = ($urandom % 6) == 0;
                ad  = 2'($urandom % 4);
                be  = ($urandom % 5 == 0) ? 2'($urandom % 3) : 2'b11;
                wd  = 16'(1 + $urandom % 8);
                step(tk, bv, 1'($urandom % 2), sel, wr, ad, be, wd, "R1");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule